// File: doc/BRIEF.md
# Cascadable 8-bit Timer Bank

The block holds four identical 8-bit up-counters, numbered 0 to 3. Each counter has its own compare register, its own count-source selection, a match interrupt pulse and a square-wave output that flips on every match. A counter advances on a strobe chosen from a set of prescaled clock-enable inputs, or on a rising edge of an external event pin. It counts only while its run bit is set.

A join bit in each counter's control register links that counter to the one below it. When linked, the upper counter advances on the carry out of the lower one. The linked counters then behave as one wider counter whose count and compare value are the concatenation of the members' bytes. The legal groupings are 0+1, 0+1+2, 2+3 and 0+1+2+3. The run bit and source selection of the group's lowest member govern the whole group. Only the group's highest member drives its interrupt and square-wave output.

Software programs the bank through a single-cycle write port. The counter values are visible on a flat output bus.

Top module: `ctb_bank`

## Requirements
- R1: After reset, all counters are zero, no interrupt is raised, all square-wave outputs are low, and all control registers are clear, so every counter is stopped.
- R2: Address decoding is as follows. wr_addr 0 to 3 writes the compare register of counter n, and wr_addr 4 to 7 writes the control register of counter n-4. The control bits are: bit 0 run, bits 3:1 source select, bit 4 join.
- R3: A group counts only on a selected strobe while its run bit is set. Source codes 0 to 6 pick src_tick bit 0 to 6, and code 7 picks the external event.
- R4: On a counting strobe where the group count equals the group compare value, the group count returns to zero. The group's top counter then shows a one-cycle irq pulse and a toggled sq output after that same clock edge. On every other counting strobe the group count increments by one.
- R5: Setting join in counter 1 forms a 16-bit counter {1,0}. Counter 1 advances on the carry of counter 0 from 0xFF. Only counter 1 drives irq and sq.
- R6: Setting join in counters 1 and 2 forms a 24-bit counter {2,1,0}, with the match taken on the full 24-bit value.
- R7: The join bit of counter 2 has no effect unless counter 1 is also joined. In that case counter 2 runs alone.
- R8: Join in counter 3 alone forms the 16-bit counter {3,2}. With joins in counters 1, 2 and 3, the four counters form one 32-bit counter.
- R9: The run and source bits of a non-lowest group member are ignored.
- R10: evt_i passes through two synchroniser flops, and each low-to-high transition counts once, however long the level is held.
- R11: Writing a compare register while that counter's group is stopped clears that counter. While the group is running, the same write leaves the count alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| src_tick | input | 7 | Prescaled clock-enable strobes |
| evt_i | input | 1 | Asynchronous external event |
| cnt_o | output | 32 | Counter values, counter n in bits 8n+7:8n |
| irq_o | output | 4 | One-cycle match interrupt per counter |
| sq_o | output | 4 | Square-wave output per counter |

## Verification
Two kinds of event can land on the same clock edge: a compare-register write and a counting strobe that either matches or carries. The same holds for a group's match and a carry that would ripple into the upper member. The random phase drives writes to every address while strobes and events run freely, including writes to counters whose group starts or stops on that edge. Each cycle, a bench model that treats every group as one wide integer predicts the counts, irq and sq, and the bench compares them with the design.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    parameter int unsigned TW   = 8;
    parameter int unsigned NT   = 4;
    parameter int unsigned NSRC = 7;
    parameter int unsigned SELW = 3;

    localparam logic [SELW-1:0] SEL_EVT = '1;

    // control register layout: {join, sel, run}
    typedef struct packed {
        logic            join_lo;
        logic [SELW-1:0] sel;
        logic            run;
    } tctl_t;

    localparam int unsigned CTLW = $bits(tctl_t);
endpackage

// File: rtl/ctb_evsync.sv
module ctb_evsync (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = evt_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.s3;
endmodule

// File: rtl/ctb_regs.sv
module ctb_regs
    import ctb_pkg::*;
#(
    parameter int unsigned NT_P = 4,
    parameter int unsigned TW_P = 8,
    parameter int unsigned AW_P = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW_P-1:0]            wr_addr,
    input  logic [TW_P-1:0]            wr_data,
    output logic [NT_P-1:0][TW_P-1:0]  cmp_o,
    output tctl_t [NT_P-1:0]           ctl_o,
    output logic [NT_P-1:0]            wcmp_o
);
    typedef struct packed {
        logic [NT_P-1:0][TW_P-1:0] cmp;
        tctl_t [NT_P-1:0]          ctl;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d   = rg_q;
        wcmp_o = '0;
        for (int i = 0; i < int'(NT_P); i++) begin
            if (wr_en && (int'(wr_addr) == i)) begin
                rg_d.cmp[i] = wr_data;
                wcmp_o[i]   = 1'b1;
            end
            if (wr_en && (int'(wr_addr) == i + int'(NT_P))) begin
                rg_d.ctl[i] = tctl_t'(wr_data[CTLW-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign cmp_o = rg_q.cmp;
    assign ctl_o = rg_q.ctl;
endmodule

// File: rtl/ctb_chain.sv
module ctb_chain
    import ctb_pkg::*;
#(
    parameter int unsigned NT_P   = 4,
    parameter int unsigned TW_P   = 8,
    parameter int unsigned NSRC_P = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  tctl_t [NT_P-1:0]           ctl_i,
    input  logic [NT_P-1:0][TW_P-1:0]  cmp_i,
    input  logic [NSRC_P-1:0]          src_tick_i,
    input  logic                       evt_rise_i,
    input  logic [NT_P-1:0]            wcmp_i,
    output logic [NT_P-1:0][TW_P-1:0]  cnt_o,
    output logic [NT_P-1:0]            irq_o,
    output logic [NT_P-1:0]            sq_o,
    output logic [NT_P-1:0]            lnk_o,
    output logic [NT_P-1:0]            grun_o
);
    typedef struct packed {
        logic [NT_P-1:0][TW_P-1:0] cnt;
        logic [NT_P-1:0]           irq;
        logic [NT_P-1:0]           sq;
    } st_t;

    st_t st_d, st_q;

    logic [NT_P-1:0] lnk;    // counter i is joined to counter i-1
    logic [NT_P-1:0] tk;     // selected strobe of counter i as a group base
    logic [NT_P-1:0] gact;   // group of i advances this cycle
    logic [NT_P-1:0] grun;   // group of i is running
    logic [NT_P-1:0] stp;    // counter i increments (own strobe or carry)
    logic [NT_P-1:0] geq;    // bytes from group base up to i all equal
    logic [NT_P-1:0] istop;  // counter i is the top of its group
    logic [NT_P-1:0] hit;    // match at a group top
    logic [NT_P-1:0] ghit;   // the group containing i matched

    // link legality: odd counters may join below freely, even ones only
    // when the counter below is itself joined
    assign lnk[0] = 1'b0;
    for (genvar g = 1; g < int'(NT_P); g++) begin : g_lnk
        if ((g % 2) == 1) begin : g_odd
            assign lnk[g] = ctl_i[g].join_lo;
        end else begin : g_even
            assign lnk[g] = ctl_i[g].join_lo & lnk[g-1];
        end
    end

    for (genvar g = 0; g < int'(NT_P); g++) begin : g_tk
        always_comb begin
            if (ctl_i[g].sel == SEL_EVT)
                tk[g] = evt_rise_i;
            else if (int'(ctl_i[g].sel) < int'(NSRC_P))
                tk[g] = src_tick_i[ctl_i[g].sel];
            else
                tk[g] = 1'b0;
        end
        if (g == int'(NT_P) - 1) begin : g_top
            assign istop[g] = 1'b1;
        end else begin : g_mid
            assign istop[g] = ~lnk[g+1];
        end
    end

    always_comb begin
        grun[0] = ctl_i[0].run;
        gact[0] = ctl_i[0].run & tk[0];
        stp[0]  = gact[0];
        geq[0]  = (st_q.cnt[0] == cmp_i[0]);
        for (int i = 1; i < int'(NT_P); i++) begin
            if (lnk[i]) begin
                grun[i] = grun[i-1];
                gact[i] = gact[i-1];
                stp[i]  = stp[i-1] & (&st_q.cnt[i-1]);
                geq[i]  = geq[i-1] & (st_q.cnt[i] == cmp_i[i]);
            end else begin
                grun[i] = ctl_i[i].run;
                gact[i] = ctl_i[i].run & tk[i];
                stp[i]  = gact[i];
                geq[i]  = (st_q.cnt[i] == cmp_i[i]);
            end
        end
        for (int i = 0; i < int'(NT_P); i++) begin
            hit[i] = istop[i] & gact[i] & geq[i];
        end
        ghit[NT_P-1] = hit[NT_P-1];
        for (int i = int'(NT_P) - 2; i >= 0; i--) begin
            ghit[i] = lnk[i+1] ? ghit[i+1] : hit[i];
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = hit;
        st_d.sq  = st_q.sq ^ hit;
        for (int i = 0; i < int'(NT_P); i++) begin
            if (ghit[i] || (wcmp_i[i] && !grun[i]))
                st_d.cnt[i] = '0;
            else if (stp[i])
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign irq_o  = st_q.irq;
    assign sq_o   = st_q.sq;
    assign lnk_o  = lnk;
    assign grun_o = grun;
endmodule

// File: rtl/ctb_bank.sv
module ctb_bank
    import ctb_pkg::*;
#(
    parameter int unsigned NT   = ctb_pkg::NT,
    parameter int unsigned TW   = ctb_pkg::TW,
    parameter int unsigned NSRC = ctb_pkg::NSRC,
    localparam int unsigned AW  = $clog2(2 * NT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [TW-1:0]      wr_data,
    input  logic [NSRC-1:0]    src_tick,
    input  logic               evt_i,
    output logic [NT*TW-1:0]   cnt_o,
    output logic [NT-1:0]      irq_o,
    output logic [NT-1:0]      sq_o
);
    logic [NT-1:0][TW-1:0] cmp_w;
    tctl_t [NT-1:0]        ctl_w;
    logic [NT-1:0]         wcmp_w;
    logic                  rise_w;
    logic [NT-1:0][TW-1:0] cnt_w;
    logic [NT-1:0]         lnk_w;
    logic [NT-1:0]         grun_w;

    ctb_evsync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .rise_o (rise_w)
    );

    ctb_regs #(.NT_P(NT), .TW_P(TW), .AW_P(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmp_o   (cmp_w),
        .ctl_o   (ctl_w),
        .wcmp_o  (wcmp_w)
    );

    ctb_chain #(.NT_P(NT), .TW_P(TW), .NSRC_P(NSRC)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_i      (ctl_w),
        .cmp_i      (cmp_w),
        .src_tick_i (src_tick),
        .evt_rise_i (rise_w),
        .wcmp_i     (wcmp_w),
        .cnt_o      (cnt_w),
        .irq_o      (irq_o),
        .sq_o       (sq_o),
        .lnk_o      (lnk_w),
        .grun_o     (grun_w)
    );

    assign cnt_o = cnt_w;
endmodule

// File: rtl/ctb_bank_chk.sv
module ctb_bank_chk #(
    parameter int unsigned NT = 4,
    parameter int unsigned TW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NT*TW-1:0] cnt_o,
    input logic [NT-1:0]    irq_o,
    input logic [NT-1:0]    sq_o,
    input logic [NT-1:0]    lnk,
    input logic [NT-1:0]    grun,
    input logic [NT-1:0]    wcmp
);
    for (genvar g = 0; g < int'(NT); g++) begin : g_chk
        // R4: an interrupt comes with a toggled square wave
        a_r4_sq_toggle: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |-> (sq_o[g] != $past(sq_o[g])));
        // R4: an interrupt comes with a cleared counter
        a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] |-> (cnt_o[g*TW +: TW] == '0));
        // R4: a counter only steps by one or returns to zero
        a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_o[g*TW +: TW] != $past(cnt_o[g*TW +: TW])) |->
            ((cnt_o[g*TW +: TW] == $past(cnt_o[g*TW +: TW]) + 1'b1) ||
             (cnt_o[g*TW +: TW] == '0)));
        // R11: a stopped group without a compare write holds its count
        a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!grun[g] && !wcmp[g]) |=> $stable(cnt_o[g*TW +: TW]));
        if (g < int'(NT) - 1) begin : g_low
            // R5: a counter with a joined neighbour above stays silent
            a_r5_low_silent: assert property (@(posedge clk) disable iff (!rst_n)
                $past(lnk[g+1]) |-> !irq_o[g]);
        end
    end
endmodule

bind ctb_bank ctb_bank_chk #(.NT(NT), .TW(TW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt_o),
    .irq_o (irq_o),
    .sq_o  (sq_o),
    .lnk   (lnk_w),
    .grun  (grun_w),
    .wcmp  (wcmp_w)
);

// File: tb/sim_ctb_bank.sv
module sim_ctb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [6:0]  src_tick = '0;
    logic        evt_i = 1'b0;
    logic [31:0] cnt_o;
    logic [3:0]  irq_o;
    logic [3:0]  sq_o;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // bench model
    logic [7:0] m_cnt [4];
    logic [7:0] m_cmp [4];
    logic       m_run [4];
    logic [2:0] m_sel [4];
    logic       m_join[4];
    logic [3:0] m_irq, m_sq;
    logic       s1, s2, s3;

    always #4 clk = ~clk;

    ctb_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .src_tick(src_tick), .evt_i(evt_i),
        .cnt_o(cnt_o), .irq_o(irq_o), .sq_o(sq_o)
    );

    function automatic logic [31:0] mcat();
        return {m_cnt[3], m_cnt[2], m_cnt[1], m_cnt[0]};
    endfunction

    task automatic chk(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act %h exp %h", t, what, act, exp);
        end
    endtask

    task automatic model_step(input logic we, input logic [2:0] a,
                              input logic [7:0] d, input logic [6:0] tk,
                              input logic ev);
        logic       rise;
        logic [3:0] lk, hit;
        int         base [4];
        logic [7:0] nc [4];
        rise = s2 & ~s3;
        s3 = s2; s2 = s1; s1 = ev;
        lk[0] = 1'b0;
        for (int i = 1; i < 4; i++)
            lk[i] = m_join[i] & (((i % 2) == 1) ? 1'b1 : lk[i-1]);
        for (int i = 0; i < 4; i++) begin
            base[i] = lk[i] ? base[i-1] : i;
            nc[i] = m_cnt[i];
        end
        hit = '0;
        for (int b = 0; b < 4; b++) begin
            if (!lk[b]) begin
                int t = b;
                logic [63:0] val = '0, cv = '0, mask;
                logic tkv;
                while (t < 3 && lk[t+1]) t++;
                for (int k = t; k >= b; k--) begin
                    val = (val << 8) | 64'(m_cnt[k]);
                    cv  = (cv << 8) | 64'(m_cmp[k]);
                end
                mask = (64'd1 << (8 * (t - b + 1))) - 1;
                tkv = (m_sel[b] == 3'd7) ? rise : tk[m_sel[b]];
                if (m_run[b] && tkv) begin
                    if (val == cv) begin
                        val = '0;
                        hit[t] = 1'b1;
                    end else begin
                        val = (val + 1) & mask;
                    end
                    for (int k = b; k <= t; k++) nc[k] = val[8*(k-b) +: 8];
                end
            end
        end
        if (we) begin
            if (a < 3'd4) begin
                if (!m_run[base[a]]) nc[a] = '0;
                m_cmp[a] = d;
            end else begin
                m_run[a-4]  = d[0];
                m_sel[a-4]  = d[3:1];
                m_join[a-4] = d[4];
            end
        end
        for (int i = 0; i < 4; i++) m_cnt[i] = nc[i];
        m_irq = hit;
        m_sq  = m_sq ^ hit;
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic we, input logic [2:0] a, input logic [7:0] d,
                       input logic [6:0] tk, input logic ev);
        wr_en = we; wr_addr = a; wr_data = d; src_tick = tk; evt_i = ev;
        @(posedge clk);
        model_step(we, a, d, tk, ev);
        @(negedge clk);
        chk(tag, "cnt", cnt_o, mcat());
        chk(tag, "irq/sq", {24'd0, irq_o, sq_o}, {24'd0, m_irq, m_sq});
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b1, a, d, 7'd0, evt_i);
    endtask

    task automatic run_ticks(input int n, input logic [6:0] tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, tk, evt_i);
    endtask

    // stop everything and clear all counters
    task automatic quiesce();
        for (int i = 0; i < 4; i++) wr(3'(4 + i), 8'h00);
        for (int i = 0; i < 4; i++) wr(3'(i), 8'h00);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired act 0 exp 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int irq_seen;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 0; m_cmp[i] = 0; m_run[i] = 0; m_sel[i] = 0; m_join[i] = 0;
        end
        m_irq = 0; m_sq = 0; s1 = 0; s2 = 0; s3 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cnt", cnt_o, 32'd0);
        chk("R1", "irq/sq", {24'd0, irq_o, sq_o}, 32'd0);
        // R1: stopped after reset, ticks change nothing
        tag = "R1";
        run_ticks(5, 7'h7f);
        chk("R1", "cnt held", cnt_o, 32'd0);

        // R2, R3, R4: single counter on source 2, compare 5
        tag = "R4";
        wr(3'd0, 8'd5);
        wr(3'd4, {3'b000, 1'b0, 3'd2, 1'b1});
        for (int i = 0; i < 60; i++)
            cyc(1'b0, 3'd0, 8'd0, 7'($urandom), 1'b0);
        // R3: other sources do not advance counter 0
        tag = "R3";
        run_ticks(20, 7'b1111011);
        // R11: write compare while running leaves count; while stopped clears
        tag = "R11";
        run_ticks(3, 7'b0000100);
        wr(3'd0, 8'd200);
        wr(3'd4, 8'h04);
        run_ticks(2, 7'h00);
        wr(3'd0, 8'd9);
        chk("R11", "cnt0 cleared", {24'd0, cnt_o[7:0]}, 32'd0);

        // R5, R9: 16-bit {1,0}, upper run/sel set but ignored
        tag = "R5";
        quiesce();
        wr(3'd0, 8'h03); wr(3'd1, 8'h02);
        wr(3'd5, {3'b000, 1'b1, 3'd5, 1'b1});
        wr(3'd4, {3'b000, 1'b0, 3'd0, 1'b1});
        irq_seen = 0;
        for (int i = 0; i < 1100; i++) begin
            cyc(1'b0, 3'd0, 8'd0, {1'b0, 1'($urandom), 5'b00001}, 1'b0);
            if (irq_o[1]) irq_seen++;
        end
        tag = "R9";
        chk("R5", "irq1 pulses", 32'(irq_seen), 32'd2);

        // R7: join on counter 2 without counter 1 joined
        tag = "R7";
        quiesce();
        wr(3'd1, 8'd6); wr(3'd2, 8'd4);
        wr(3'd6, {3'b000, 1'b1, 3'd3, 1'b1});
        wr(3'd5, {3'b000, 1'b0, 3'd3, 1'b1});
        run_ticks(40, 7'b0001000);

        // R8: 2+3 pairing with counters 0 and 1 independent
        tag = "R8";
        quiesce();
        wr(3'd2, 8'h20); wr(3'd3, 8'h01); wr(3'd0, 8'd7);
        wr(3'd7, {3'b000, 1'b1, 3'd0, 1'b0});
        wr(3'd6, {3'b000, 1'b0, 3'd1, 1'b1});
        wr(3'd4, {3'b000, 1'b0, 3'd1, 1'b1});
        run_ticks(700, 7'b0000010);
        // R8: 32-bit group
        quiesce();
        wr(3'd0, 8'd6);
        wr(3'd5, 8'h10); wr(3'd6, 8'h10); wr(3'd7, 8'h10);
        wr(3'd4, {3'b000, 1'b0, 3'd4, 1'b1});
        run_ticks(30, 7'b0010000);

        // R6: 24-bit {2,1,0} with carry into counter 2
        tag = "R6";
        quiesce();
        wr(3'd0, 8'h02); wr(3'd1, 8'h00); wr(3'd2, 8'h01);
        wr(3'd5, 8'h10); wr(3'd6, 8'h10);
        wr(3'd4, {3'b000, 1'b0, 3'd6, 1'b1});
        run_ticks(65545, 7'b1000000);

        // R10: external event, held levels count once
        tag = "R10";
        quiesce();
        wr(3'd0, 8'd250);
        wr(3'd4, {3'b000, 1'b0, 3'd7, 1'b1});
        for (int i = 0; i < 10; i++) cyc(1'b0, 3'd0, 8'd0, 7'h7f, 1'b1);
        chk("R10", "held event counts once", {24'd0, cnt_o[7:0]}, 32'd1);
        for (int i = 0; i < 400; i++)
            cyc(1'b0, 3'd0, 8'd0, 7'($urandom), 1'($urandom));

        // R2: random writes on every address mixed with strobes and events
        tag = "R2";
        quiesce();
        for (int i = 0; i < 6000; i++) begin
            logic we = (($urandom % 16) == 0);
            cyc(we, 3'($urandom), 8'($urandom % 32), 7'($urandom), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule